// File: doc/BRIEF.md
# Frame Header Format Decoder

This block sits beside a display controller's fetch engine and is consulted once at the start of every displayed frame. The controller hands it the first 16-bit word of the frame buffer's palette area, the current palette load mode, the panel type (active matrix or passive), the configured width and height in pixels, and the byte size of the buffer about to be scanned. The colour depth is not held in a register: it is a three-bit field inside that palette word, and the length of the palette header that precedes the pixel data in memory depends on it.

One cycle after a start strobe the block returns the bits per pixel, a pixel-format select for the line unpacker, the byte offset from the buffer base to the first pixel, the line stride in bytes, and a verdict. The verdict is accept, skip (no processing, or an unsupported depth), or sync error. A sync error means the frame's pixels would run past the buffer. The block then raises a one-cycle request that the controller clear its enable. The results hold until the next start strobe.

Top module: `frame_hdr_decoder`

## Requirements
- R1: `done_o` is high for exactly the one cycle after a cycle with `start_i` high. All result outputs change only at that edge and otherwise keep their values.
- R2: The depth code is `pal_word_i[14:12]`. Code 1 gives `bpp_o`=2 and `fmt_o`=1. Code 2 gives 4 and `fmt_o`=2. Code 3 gives 8 and `fmt_o`=3. Codes 4 to 7 give 16, with `fmt_o`=4 (12-bit colour) when `tft_i`=0 and `fmt_o`=5 (16-bit colour) when `tft_i`=1.
- R3: Depth code 0 is a skip. `accept_o`, `sync_err_o` and `disable_req_o` stay 0, and `bpp_o`, `fmt_o`, `offset_o` and `stride_o` are 0.
- R4: When `load_mode_i` is not 2, `offset_o` is 512 for depth codes 3 to 7 and 32 for codes 1 and 2. When `load_mode_i` is 2, `offset_o` is 0.
- R5: `stride_o` equals (width × bpp) / 8, with the fraction dropped.
- R6: With need = offset + (width × height × bpp) / 8 (fraction dropped), a frame with need greater than `buf_size_i` + 2 gives `sync_err_o`=1 and `accept_o`=0. `disable_req_o` is high for the done cycle only.
- R7: A frame with need exactly `buf_size_i` + 2, or less, is accepted: `accept_o`=1 and `sync_err_o`=0.
- R8: When `enable_i` is 0 or `load_mode_i` is 1, no frame processing takes place. `done_o` still pulses, and all verdict and format outputs are 0.
- R9: `accept_o` and `sync_err_o` are never both high, and `disable_req_o` is high only together with `done_o` and `sync_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-frame decode strobe |
| enable_i | input | 1 | Controller enable |
| load_mode_i | input | 2 | Palette load mode (1: no frame processing, 2: no palette header) |
| tft_i | input | 1 | Active-matrix panel flag |
| pal_word_i | input | 16 | First palette word of the frame buffer |
| width_i | input | DIM_W | Frame width in pixels |
| height_i | input | DIM_W | Frame height in lines |
| buf_size_i | input | SIZE_W | Byte size of the active buffer |
| done_o | output | 1 | Results valid pulse |
| accept_o | output | 1 | Frame may be shown |
| sync_err_o | output | 1 | Frame overruns the buffer |
| disable_req_o | output | 1 | One-cycle request to clear the enable |
| bpp_o | output | 5 | Bits per pixel (0 when skipped) |
| fmt_o | output | 3 | Pixel-format select |
| offset_o | output | OFS_W | Byte offset of pixel data past the header |
| stride_o | output | DIM_W+2 | Line stride in bytes |

## Verification
The hardest condition to bring about is the size boundary. Here the header offset, the truncated frame byte count and the two-byte slack must line up so that need equals the buffer size plus two. One byte more must flip the verdict. The directed stimulus picks an 8-bit frame of 16 × 4 pixels behind a 512-byte header, and a 2-bit frame of 5 × 3 pixels whose 30 bits truncate to 3 bytes. It then offers buffer sizes one apart on either side of the limit, so that both the slack and the truncation are exercised.

// File: rtl/fhd_pkg.sv
package fhd_pkg;
  typedef enum logic [2:0] {
    PIX_NONE = 3'd0,
    PIX_2    = 3'd1,
    PIX_4    = 3'd2,
    PIX_8    = 3'd3,
    PIX_12   = 3'd4,
    PIX_16   = 3'd5
  } pix_fmt_e;

  typedef struct packed {
    logic       valid;
    logic       hdr_long;
    logic [4:0] bpp;
    pix_fmt_e   fmt;
  } depth_t;

  localparam int unsigned HdrLongBytes  = 512;
  localparam int unsigned HdrShortBytes = 32;
  localparam int unsigned SizeSlack     = 2;
endpackage

// File: rtl/fhd_depth_decode.sv
module fhd_depth_decode
  import fhd_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       tft_i,
  output depth_t     depth_o
);
  always_comb begin
    depth_o = '{valid: 1'b0, hdr_long: 1'b0, bpp: 5'd0, fmt: PIX_NONE};
    unique case (code_i)
      3'd0: ;
      3'd1: depth_o = '{valid: 1'b1, hdr_long: 1'b0, bpp: 5'd2, fmt: PIX_2};
      3'd2: depth_o = '{valid: 1'b1, hdr_long: 1'b0, bpp: 5'd4, fmt: PIX_4};
      3'd3: depth_o = '{valid: 1'b1, hdr_long: 1'b1, bpp: 5'd8, fmt: PIX_8};
      default: depth_o = '{valid: 1'b1, hdr_long: 1'b1, bpp: 5'd16,
                           fmt: (tft_i ? PIX_16 : PIX_12)};
    endcase
  end
endmodule

// File: rtl/fhd_size_check.sv
module fhd_size_check
  import fhd_pkg::*;
#(
  parameter int unsigned DIM_W  = 11,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned OFS_W  = 10
) (
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [4:0]        bpp_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  output logic [DIM_W+1:0]  stride_o,
  output logic              overrun_o
);
  localparam int unsigned PROD_W = 2 * DIM_W + 5;
  localparam int unsigned LINE_W = DIM_W + 5;
  localparam int unsigned CMP_W  = ((PROD_W > SIZE_W) ? PROD_W : SIZE_W) + 2;

  logic [PROD_W-1:0] frame_bits;
  logic [LINE_W-1:0] line_bits;
  logic [CMP_W-1:0]  need, limit;

  assign frame_bits = PROD_W'(width_i) * PROD_W'(height_i) * PROD_W'(bpp_i);
  assign line_bits  = LINE_W'(width_i) * LINE_W'(bpp_i);
  assign stride_o   = line_bits[LINE_W-1:3];

  // truncation applies to the whole frame, not per line
  assign need      = CMP_W'(frame_bits[PROD_W-1:3]) + CMP_W'(offset_i);
  assign limit     = CMP_W'(buf_size_i) + CMP_W'(SizeSlack);
  assign overrun_o = need > limit;
endmodule

// File: rtl/frame_hdr_decoder.sv
module frame_hdr_decoder
  import fhd_pkg::*;
#(
  parameter int unsigned DIM_W  = 11,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned OFS_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  input  logic [1:0]        load_mode_i,
  input  logic              tft_i,
  input  logic [15:0]       pal_word_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  output logic              done_o,
  output logic              accept_o,
  output logic              sync_err_o,
  output logic              disable_req_o,
  output logic [4:0]        bpp_o,
  output logic [2:0]        fmt_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic [DIM_W+1:0]  stride_o
);
  localparam int unsigned STRIDE_W = DIM_W + 2;

  depth_t              depth;
  logic                active, hdr_on, overrun;
  logic [OFS_W-1:0]    offset_c;
  logic [STRIDE_W-1:0] stride_c;
  logic                pal_unused;

  assign pal_unused = ^{pal_word_i[15], pal_word_i[11:0]};

  fhd_depth_decode u_depth (
    .code_i  (pal_word_i[14:12]),
    .tft_i   (tft_i),
    .depth_o (depth)
  );

  assign active   = enable_i && (load_mode_i != 2'd1);
  assign hdr_on   = load_mode_i != 2'd2;
  assign offset_c = !hdr_on        ? '0 :
                    depth.hdr_long ? OFS_W'(HdrLongBytes) : OFS_W'(HdrShortBytes);

  fhd_size_check #(
    .DIM_W (DIM_W),
    .SIZE_W(SIZE_W),
    .OFS_W (OFS_W)
  ) u_size (
    .width_i   (width_i),
    .height_i  (height_i),
    .bpp_i     (depth.bpp),
    .offset_i  (offset_c),
    .buf_size_i(buf_size_i),
    .stride_o  (stride_c),
    .overrun_o (overrun)
  );

  logic                acc_d, err_d;
  logic [4:0]          bpp_d;
  logic [2:0]          fmt_d;
  logic [OFS_W-1:0]    ofs_d;
  logic [STRIDE_W-1:0] str_d;

  always_comb begin
    acc_d = 1'b0;
    err_d = 1'b0;
    bpp_d = '0;
    fmt_d = PIX_NONE;
    ofs_d = '0;
    str_d = '0;
    if (active && depth.valid) begin
      bpp_d = depth.bpp;
      fmt_d = depth.fmt;
      ofs_d = offset_c;
      str_d = stride_c;
      err_d = overrun;
      acc_d = !overrun;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      disable_req_o <= 1'b0;
      accept_o      <= 1'b0;
      sync_err_o    <= 1'b0;
      bpp_o         <= '0;
      fmt_o         <= '0;
      offset_o      <= '0;
      stride_o      <= '0;
    end else begin
      done_o        <= start_i;
      disable_req_o <= start_i && err_d;
      if (start_i) begin
        accept_o   <= acc_d;
        sync_err_o <= err_d;
        bpp_o      <= bpp_d;
        fmt_o      <= fmt_d;
        offset_o   <= ofs_d;
        stride_o   <= str_d;
      end
    end
  end
endmodule

// File: rtl/fhd_checker.sv
module fhd_checker #(
  parameter int unsigned DIM_W = 11,
  parameter int unsigned OFS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             enable_i,
  input logic [1:0]       load_mode_i,
  input logic             done_o,
  input logic             accept_o,
  input logic             sync_err_o,
  input logic             disable_req_o,
  input logic [4:0]       bpp_o,
  input logic [OFS_W-1:0] offset_o,
  input logic [DIM_W+1:0] stride_o
);
  assert_done_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_hold_results_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(bpp_o) && $stable(offset_o) && $stable(stride_o)
                  && $stable(accept_o) && $stable(sync_err_o)));
  assert_no_header_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && load_mode_i == 2'd2) |=> offset_o == '0);
  assert_idle_no_verdict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (!enable_i || load_mode_i == 2'd1)) |=>
      (!accept_o && !sync_err_o && bpp_o == 5'd0));
  assert_verdict_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && sync_err_o));
  assert_disable_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_req_o |-> (done_o && sync_err_o));
  assert_accept_has_depth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (bpp_o != 5'd0));
endmodule

bind frame_hdr_decoder fhd_checker #(.DIM_W(DIM_W), .OFS_W(OFS_W)) u_fhd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .enable_i     (enable_i),
  .load_mode_i  (load_mode_i),
  .done_o       (done_o),
  .accept_o     (accept_o),
  .sync_err_o   (sync_err_o),
  .disable_req_o(disable_req_o),
  .bpp_o        (bpp_o),
  .offset_o     (offset_o),
  .stride_o     (stride_o)
);

// File: tb/tb_frame_hdr_decoder.sv
`timescale 1ns/1ps
module tb_frame_hdr_decoder;
  localparam int DIM_W = 11;
  localparam int SIZE_W = 32;
  localparam int OFS_W = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, enable_i = 1'b0, tft_i = 1'b0;
  logic [1:0] load_mode_i = 2'd0;
  logic [15:0] pal_word_i = '0;
  logic [DIM_W-1:0] width_i = '0, height_i = '0;
  logic [SIZE_W-1:0] buf_size_i = '0;
  logic done_o, accept_o, sync_err_o, disable_req_o;
  logic [4:0] bpp_o;
  logic [2:0] fmt_o;
  logic [OFS_W-1:0] offset_o;
  logic [DIM_W+1:0] stride_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  frame_hdr_decoder #(.DIM_W(DIM_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)) dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one frame, outputs are sampled on the following falling edge
  task automatic run(input logic en, input logic [1:0] lm, input logic tft,
                     input int code, input int w, input int h, input longint sz);
    @(negedge clk_i);
    enable_i = en; load_mode_i = lm; tft_i = tft;
    pal_word_i = 16'h8a5c & ~16'h7000 | 16'((code & 7) << 12);
    width_i = DIM_W'(w); height_i = DIM_W'(h); buf_size_i = SIZE_W'(sz);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset done", done_o, 0);
    chk("R9 reset accept", accept_o, 0);
    chk("R9 reset sync_err", sync_err_o, 0);
    chk("R1 reset bpp", bpp_o, 0);
  endtask

  task automatic t_depths;
    int bpp_e, fmt_e, ofs_e;
    for (int c = 1; c < 8; c++) begin
      for (int t = 0; t < 2; t++) begin
        run(1'b1, 2'd0, t[0], c, 24, 4, 100000);
        bpp_e = (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 16;
        fmt_e = (c < 4) ? c : (t == 1 ? 5 : 4);
        ofs_e = (c >= 3) ? 512 : 32;
        chk("R1 done", done_o, 1);
        chk("R2 bpp", bpp_o, bpp_e);
        chk("R2 fmt", fmt_o, fmt_e);
        chk("R4 offset", offset_o, ofs_e);
        chk("R5 stride", stride_o, (24 * bpp_e) / 8);
        chk("R7 accept", accept_o, 1);
      end
    end
  endtask

  task automatic t_no_header;
    run(1'b1, 2'd2, 1'b1, 5, 10, 2, 100000);
    chk("R4 mode2 offset", offset_o, 0);
    chk("R2 mode2 bpp", bpp_o, 16);
    run(1'b1, 2'd3, 1'b0, 2, 10, 2, 100000);
    chk("R4 mode3 offset", offset_o, 32);
  endtask

  task automatic t_code0;
    run(1'b1, 2'd0, 1'b1, 0, 2000, 2000, 0);
    chk("R3 accept", accept_o, 0);
    chk("R3 sync_err", sync_err_o, 0);
    chk("R3 disable_req", disable_req_o, 0);
    chk("R3 bpp", bpp_o, 0);
    chk("R3 fmt", fmt_o, 0);
    chk("R3 offset", offset_o, 0);
    chk("R3 stride", stride_o, 0);
  endtask

  task automatic t_boundary;
    // 8 bpp 16x4 -> 64 bytes + 512 header = 576
    run(1'b1, 2'd0, 1'b0, 3, 16, 4, 574);
    chk("R7 edge accept", accept_o, 1);
    chk("R7 edge sync_err", sync_err_o, 0);
    run(1'b1, 2'd0, 1'b0, 3, 16, 4, 573);
    chk("R6 over sync_err", sync_err_o, 1);
    chk("R6 over accept", accept_o, 0);
    chk("R6 disable_req pulse", disable_req_o, 1);
    @(negedge clk_i);
    chk("R6 disable_req ends", disable_req_o, 0);
    chk("R6 sync_err held", sync_err_o, 1);
    // 2 bpp 5x3 -> 30 bits = 3 bytes + 32 = 35
    run(1'b1, 2'd0, 1'b0, 1, 5, 3, 33);
    chk("R7 trunc accept", accept_o, 1);
    chk("R5 trunc stride", stride_o, 1);
    run(1'b1, 2'd0, 1'b0, 1, 5, 3, 32);
    chk("R6 trunc sync_err", sync_err_o, 1);
  endtask

  task automatic t_idle;
    run(1'b1, 2'd1, 1'b1, 4, 8, 8, 100000);
    chk("R8 mode1 done", done_o, 1);
    chk("R8 mode1 accept", accept_o, 0);
    chk("R8 mode1 bpp", bpp_o, 0);
    run(1'b0, 2'd0, 1'b1, 4, 2000, 2000, 0);
    chk("R8 disabled sync_err", sync_err_o, 0);
    chk("R8 disabled accept", accept_o, 0);
    chk("R8 disabled disable_req", disable_req_o, 0);
    chk("R8 disabled offset", offset_o, 0);
  endtask

  task automatic t_hold;
    run(1'b1, 2'd0, 1'b1, 6, 40, 2, 100000);
    @(negedge clk_i);
    pal_word_i = 16'h1000; width_i = 11'd3; tft_i = 1'b0; buf_size_i = '0;
    @(negedge clk_i);
    chk("R1 done low", done_o, 0);
    chk("R1 hold bpp", bpp_o, 16);
    chk("R1 hold fmt", fmt_o, 5);
    chk("R1 hold stride", stride_o, 80);
    chk("R1 hold accept", accept_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_depths();
    t_no_header();
    t_code0();
    t_boundary();
    t_idle();
    t_hold();
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule